// File: doc/BRIEF.md
# Audio Level Detector with Noise Gate

This block watches a stream of signed PCM samples and condenses each measurement window into the level figures an automatic gain loop needs. While a window is open it keeps the largest and smallest sample seen and the largest magnitude seen. A window-end strobe freezes the magnitude peak and the peak-to-peak swing into result registers and starts a new window at the next valid sample.

From the frozen results the block derives two level choices, each with its own source select. One feeds a noise gate, which compares it against a threshold programmed in 6 dB steps with an optional 6 dB lower offset. The other is handed to the gain-training logic. A separate clip detector flags any sample whose magnitude goes past seven eighths of full scale. Coarse readback fields carry the upper bits of both frozen results.

Top module: `audio_level_meter`

## Requirements
- R1: After reset the frozen peak and peak-to-peak results are zero and the clip flag is low, so `peak_rb`, `p2p_rb` and `train_level` read 0.
- R2: One cycle after a clock edge with `win_end` high, the frozen peak equals the largest magnitude among the valid samples of the window, including a valid sample in the strobe cycle itself. `peak_rb` is bits [15:8] of that 16-bit magnitude, so -32768 gives magnitude 32768.
- R3: The frozen peak-to-peak value is the 17-bit difference between the largest and the smallest valid sample of the window, and `p2p_rb` is bits [16:8] of it. A window with one valid sample gives 0. A window with no valid sample gives 0 for both results.
- R4: After a strobe, the next window holds only samples taken after that strobe. Between strobes the frozen results and readbacks do not change.
- R5: The clip flag is registered. It goes high after a valid sample whose magnitude is above 28672 and low after a valid sample whose magnitude is 28672 or less. It holds while `smp_valid` is low.
- R6: The gate threshold for code N (0..7) is the linear magnitude round(32768·10^(dB/20)), where dB = -81+6N with `gate_boost`=0 and dB = -87+6N with `gate_boost`=1. Over -87 to -39 dB these are 1, 3, 6, 12, 23, 46, 92, 184 and 368.
- R7: `noise_flag` is high exactly when `gate_en` is 1 and the gate level is below the threshold of R6. The gate level is the frozen peak-to-peak value when `gate_src_sel`=0 and the frozen peak when it is 1. The flag follows configuration changes in the same cycle.
- R8: `train_level` is the frozen peak, zero-extended to 17 bits, when `train_src_sel`=0, and the frozen peak-to-peak value when it is 1.
- R9: Cycles with `smp_valid` low leave the window contents and the clip flag unchanged, whatever `smp_data` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Qualifies `smp_data` in this cycle |
| smp_data | input | 16 | Two's complement audio sample |
| win_end | input | 1 | Closes the current window and freezes its results |
| gate_en | input | 1 | Enables the noise flag |
| gate_boost | input | 1 | Lowers the gate threshold by 6 dB |
| gate_thr | input | 3 | Gate threshold code |
| gate_src_sel | input | 1 | Gate level: 0 peak-to-peak, 1 peak |
| train_src_sel | input | 1 | Training level: 0 peak, 1 peak-to-peak |
| noise_flag | output | 1 | Gate level below threshold |
| clip_flag | output | 1 | Last valid sample was beyond 7/8 of full scale |
| p2p_rb | output | 9 | Upper bits of frozen peak-to-peak |
| peak_rb | output | 8 | Upper bits of frozen peak |
| train_level | output | 17 | Level handed to gain training |

## Verification
The hardest cases to reach are the gate comparisons at the smallest thresholds. They need windows whose whole swing is only a few LSBs, and those almost never turn up in uniform random data. The stimulus therefore mixes near-silent samples into the random windows, adds directed windows with one sample and with no sample, and sweeps every threshold code, boost setting and source select after each window. The same bias puts samples right at the clip limit, at full-scale extremes, and at the strobe cycle itself.

// File: rtl/lvl_pkg.sv
package lvl_pkg;

    // Linear magnitude of a 16-bit full-scale signal at dB = -87 + 6*idx,
    // rounded to the nearest integer.
    function automatic logic [16:0] gate_lin_thr(input logic [3:0] idx);
        logic [16:0] v;
        case (idx)
            4'd0:    v = 17'd1;
            4'd1:    v = 17'd3;
            4'd2:    v = 17'd6;
            4'd3:    v = 17'd12;
            4'd4:    v = 17'd23;
            4'd5:    v = 17'd46;
            4'd6:    v = 17'd92;
            4'd7:    v = 17'd184;
            default: v = 17'd368;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/lvl_window_tracker.sv
module lvl_window_tracker #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid,
    input  logic [W-1:0] smp_data,
    input  logic         win_end,
    output logic [W-1:0] held_peak,
    output logic [W:0]   held_p2p
);
    typedef struct packed {
        logic [W-1:0] hmax;
        logic [W-1:0] hmin;
        logic [W-1:0] hpeak;
        logic         seen;
        logic [W-1:0] lpeak;
        logic [W:0]   lp2p;
    } trk_t;

    trk_t st_d, st_q;
    logic [W-1:0] mag_d;
    logic [W-1:0] emax_d, emin_d, epeak_d;
    logic         eseen_d;

    always_comb begin
        st_d    = st_q;
        mag_d   = smp_data[W-1] ? (~smp_data + 1'b1) : smp_data;
        emax_d  = st_q.hmax;
        emin_d  = st_q.hmin;
        epeak_d = st_q.hpeak;
        eseen_d = st_q.seen;
        if (smp_valid) begin
            if (!st_q.seen) begin
                emax_d  = smp_data;
                emin_d  = smp_data;
                epeak_d = mag_d;
            end else begin
                if ($signed(smp_data) > $signed(st_q.hmax)) emax_d = smp_data;
                if ($signed(smp_data) < $signed(st_q.hmin)) emin_d = smp_data;
                if (mag_d > st_q.hpeak) epeak_d = mag_d;
            end
            eseen_d = 1'b1;
        end
        st_d.hmax  = emax_d;
        st_d.hmin  = emin_d;
        st_d.hpeak = epeak_d;
        st_d.seen  = eseen_d;
        if (win_end) begin
            st_d.lpeak = eseen_d ? epeak_d : '0;
            st_d.lp2p  = eseen_d ? ({emax_d[W-1], emax_d} - {emin_d[W-1], emin_d}) : '0;
            st_d.seen  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held_peak = st_q.lpeak;
    assign held_p2p  = st_q.lp2p;
endmodule

// File: rtl/lvl_clip_detect.sv
module lvl_clip_detect #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid,
    input  logic [W-1:0] smp_data,
    output logic         clip
);
    localparam logic [W-1:0] CLIP_LIM = W'(7) << (W - 4);

    logic [W-1:0] mag_d;
    logic         clip_d, clip_q;

    always_comb begin
        mag_d  = smp_data[W-1] ? (~smp_data + 1'b1) : smp_data;
        clip_d = clip_q;
        if (smp_valid) clip_d = (mag_d > CLIP_LIM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clip_q <= 1'b0;
        else        clip_q <= clip_d;
    end

    assign clip = clip_q;
endmodule

// File: rtl/lvl_route_gate.sv
module lvl_route_gate #(
    parameter int W = 16
) (
    input  logic [W-1:0] held_peak,
    input  logic [W:0]   held_p2p,
    input  logic         gate_en,
    input  logic         gate_boost,
    input  logic [2:0]   gate_thr,
    input  logic         gate_src_sel,
    input  logic         train_src_sel,
    output logic         noise,
    output logic [W:0]   train_lvl
);
    import lvl_pkg::*;

    localparam int SHIFT = W - 16;

    logic [W:0] peak_ext_d;
    logic [W:0] gate_lvl_d;
    logic [W:0] thr_d;
    logic [3:0] idx_d;

    always_comb begin
        peak_ext_d = {1'b0, held_peak};
        idx_d      = {1'b0, gate_thr} + {3'b000, ~gate_boost};
        thr_d      = (W+1)'(gate_lin_thr(idx_d)) << SHIFT;
        gate_lvl_d = gate_src_sel ? peak_ext_d : held_p2p;
        noise      = gate_en && (gate_lvl_d < thr_d);
        train_lvl  = train_src_sel ? held_p2p : peak_ext_d;
    end
endmodule

// File: rtl/audio_level_meter.sv
module audio_level_meter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid,
    input  logic [W-1:0] smp_data,
    input  logic         win_end,
    input  logic         gate_en,
    input  logic         gate_boost,
    input  logic [2:0]   gate_thr,
    input  logic         gate_src_sel,
    input  logic         train_src_sel,
    output logic         noise_flag,
    output logic         clip_flag,
    output logic [8:0]   p2p_rb,
    output logic [7:0]   peak_rb,
    output logic [W:0]   train_level
);
    logic [W-1:0] held_peak;
    logic [W:0]   held_p2p;

    lvl_window_tracker #(.W(W)) u_trk (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .win_end(win_end), .held_peak(held_peak), .held_p2p(held_p2p)
    );

    lvl_clip_detect #(.W(W)) u_clip (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .clip(clip_flag)
    );

    lvl_route_gate #(.W(W)) u_gate (
        .held_peak(held_peak), .held_p2p(held_p2p), .gate_en(gate_en),
        .gate_boost(gate_boost), .gate_thr(gate_thr), .gate_src_sel(gate_src_sel),
        .train_src_sel(train_src_sel), .noise(noise_flag), .train_lvl(train_level)
    );

    assign p2p_rb  = held_p2p[W -: 9];
    assign peak_rb = held_peak[W-1 -: 8];
endmodule

// File: rtl/lvl_checker.sv
module lvl_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         smp_valid,
    input logic [W-1:0] smp_data,
    input logic         win_end,
    input logic         gate_en,
    input logic         train_src_sel,
    input logic         noise_flag,
    input logic         clip_flag,
    input logic [8:0]   p2p_rb,
    input logic [7:0]   peak_rb,
    input logic [W:0]   train_level
);
    logic [W-1:0] chk_mag;
    assign chk_mag = smp_data[W-1] ? (W'(0) - smp_data) : smp_data;

    assert_clip_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && chk_mag > (W'(7) << (W - 4))) |=> clip_flag);

    assert_clip_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && chk_mag <= (W'(7) << (W - 4))) |=> !clip_flag);

    assert_clip_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(clip_flag));

    assert_results_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> ($stable(p2p_rb) && $stable(peak_rb)));

    assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |-> !noise_flag);

    assert_train_peak_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !train_src_sel |-> (train_level[W] == 1'b0 && train_level[W-1 -: 8] == peak_rb));

    assert_train_p2p_R8: assert property (@(posedge clk) disable iff (!rst_n)
        train_src_sel |-> (train_level[W -: 9] == p2p_rb));
endmodule

bind audio_level_meter lvl_checker #(.W(W)) u_lvl_checker (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .win_end(win_end), .gate_en(gate_en), .train_src_sel(train_src_sel),
    .noise_flag(noise_flag), .clip_flag(clip_flag), .p2p_rb(p2p_rb),
    .peak_rb(peak_rb), .train_level(train_level)
);

// File: tb/audio_level_meter_bench.sv
module audio_level_meter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        win_end = 1'b0;
    logic        gate_en = 1'b0;
    logic        gate_boost = 1'b0;
    logic [2:0]  gate_thr = '0;
    logic        gate_src_sel = 1'b0;
    logic        train_src_sel = 1'b0;
    logic        noise_flag, clip_flag;
    logic [8:0]  p2p_rb;
    logic [7:0]  peak_rb;
    logic [16:0] train_level;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model
    int  m_max, m_min, m_peak;
    bit  m_seen = 1'b0;
    int  f_peak = 0, f_p2p = 0;
    bit  m_clip = 1'b0;

    always #10 clk = ~clk;

    audio_level_meter u_audio_level_meter (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .win_end(win_end), .gate_en(gate_en), .gate_boost(gate_boost),
        .gate_thr(gate_thr), .gate_src_sel(gate_src_sel), .train_src_sel(train_src_sel),
        .noise_flag(noise_flag), .clip_flag(clip_flag), .p2p_rb(p2p_rb),
        .peak_rb(peak_rb), .train_level(train_level)
    );

    function automatic int exp_thr(input int code, input bit boost);
        real db;
        db = (boost ? -87.0 : -81.0) + 6.0 * code;
        return $rtoi(32768.0 * (10.0 ** (db / 20.0)) + 0.5);
    endfunction

    task automatic check(input string req, input int act, input int exp_v);
        n_tests++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic drive(input bit v, input int d, input bit s);
        int sv, mg;
        @(negedge clk);
        smp_valid = v;
        smp_data  = d[15:0];
        win_end   = s;
        @(posedge clk);
        sv = $signed(d[15:0]);
        mg = (sv < 0) ? -sv : sv;
        if (v) begin
            if (!m_seen) begin m_max = sv; m_min = sv; m_peak = mg; end
            else begin
                if (sv > m_max) m_max = sv;
                if (sv < m_min) m_min = sv;
                if (mg > m_peak) m_peak = mg;
            end
            m_seen = 1'b1;
            m_clip = (mg > 28672);
        end
        if (s) begin
            f_peak = m_seen ? m_peak : 0;
            f_p2p  = m_seen ? (m_max - m_min) : 0;
            m_seen = 1'b0;
        end
        #2;
        smp_valid = 1'b0;
        win_end   = 1'b0;
    endtask

    task automatic check_results(input string tag);
        check({tag, " R2 peak_rb"}, int'(peak_rb), f_peak >> 8);
        check({tag, " R3 p2p_rb"}, int'(p2p_rb), f_p2p >> 8);
        train_src_sel = 1'b0; #1;
        check({tag, " R8 train peak"}, int'(train_level), f_peak);
        train_src_sel = 1'b1; #1;
        check({tag, " R8 train p2p"}, int'(train_level), f_p2p);
        train_src_sel = 1'b0;
    endtask

    task automatic check_gate(input string tag);
        int lvl, exp_n;
        for (int sel = 0; sel < 2; sel++) begin
            for (int b = 0; b < 2; b++) begin
                for (int c = 0; c < 8; c++) begin
                    gate_en = 1'b1; gate_src_sel = sel[0]; gate_boost = b[0];
                    gate_thr = c[2:0];
                    #1;
                    lvl = sel ? f_peak : f_p2p;
                    exp_n = (lvl < exp_thr(c, b[0])) ? 1 : 0;
                    check({tag, " R6 R7 noise"}, int'(noise_flag), exp_n);
                end
            end
        end
        gate_en = 1'b0; #1;
        check({tag, " R7 gate off"}, int'(noise_flag), 0);
    endtask

    function automatic int rnd_sample();
        int k, v;
        k = $urandom % 5;
        case (k)
            0: v = int'($urandom % 65536) - 32768;
            1: v = int'($urandom % 9) - 4;
            2: v = int'($urandom % 801) - 400;
            3: v = 28672 + int'($urandom % 5) - 2;
            default: v = ($urandom % 2) ? 32767 : -32768;
        endcase
        if (k == 3 && ($urandom % 2)) v = -v;
        return v;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset peak_rb", int'(peak_rb), 0);
        check("R1 reset p2p_rb", int'(p2p_rb), 0);
        check("R1 reset train", int'(train_level), 0);
        check("R1 reset clip", int'(clip_flag), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6 threshold table spot values
        check("R6 table -87", exp_thr(0, 1'b1), 1);
        check("R6 table -39", exp_thr(7, 1'b0), 368);

        // single valid sample window, strobe in the same cycle
        drive(1'b1, -1234, 1'b1);
        check("R3 single sample p2p", int'(p2p_rb), 0);
        check_results("single");
        check_gate("single");

        // empty window
        drive(1'b0, 32767, 1'b0);
        drive(1'b0, 0, 1'b1);
        check("R3 empty peak", int'(peak_rb), 0);
        check_results("empty");

        // full-scale extremes, -32768 magnitude
        drive(1'b1, 32767, 1'b0);
        drive(1'b1, -32768, 1'b0);
        check("R5 clip after -32768", int'(clip_flag), 1);
        drive(1'b0, 5, 1'b0);
        check("R9 clip held on invalid", int'(clip_flag), 1);
        drive(1'b1, 100, 1'b1);
        check("R2 peak 32768", int'(peak_rb), 128);
        check("R3 p2p 65535", int'(p2p_rb), 255);
        check_results("extreme");

        // clip limit edges
        drive(1'b1, 28673, 1'b0);
        check("R5 clip 28673", int'(clip_flag), 1);
        drive(1'b1, 28672, 1'b0);
        check("R5 clip 28672", int'(clip_flag), 0);
        drive(1'b1, -28673, 1'b0);
        check("R5 clip -28673", int'(clip_flag), 1);
        drive(1'b1, -28672, 1'b0);
        check("R5 clip -28672", int'(clip_flag), 0);
        drive(1'b0, 32767, 1'b0);
        check("R9 invalid no clip", int'(clip_flag), 0);
        drive(1'b0, 0, 1'b1);
        check_results("cliplim");

        // restart: small window after a loud one, invalid loud data ignored
        drive(1'b1, 3, 1'b0);
        drive(1'b0, -32768, 1'b0);
        drive(1'b1, 1, 1'b0);
        check("R4 frozen between strobes", int'(peak_rb), f_peak >> 8);
        drive(1'b0, 0, 1'b1);
        check("R4 R9 restart peak", f_peak, 3);
        check_results("restart");
        check_gate("restart");

        // random windows
        for (int w = 0; w < 300; w++) begin
            int len;
            len = 1 + int'($urandom % 12);
            for (int i = 0; i < len; i++) begin
                drive(($urandom % 4) != 0, rnd_sample(), i == len - 1);
                check("R5 R9 clip", int'(clip_flag), int'(m_clip));
            end
            check_results("rand");
            if (w % 4 == 0) check_gate("rand");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule